// File: doc/BRIEF.md
# DRAM strobe sequencer with CAS-before-RAS refresh

This block drives one asynchronous DRAM address space with no page mode and a single bank. For each accepted request it lowers the row strobe and then the column strobe. It switches the shared address pins from row to column just before the column strobe falls, and then holds both strobes high for a programmable precharge time. Three static two-bit fields set the timing: the row-to-column delay, the access length and the precharge length. Each field selects 1 to 4 clock cycles. When the access length is one cycle, the column strobe is low only during the low phase of the clock in that cycle.

An internal timer requests a refresh at a selectable interval, or never. A refresh lowers the column strobe one cycle ahead of the row strobe. A refresh that falls due while an access is running waits until that access and its precharge finish. It then runs at once, ahead of any request that is waiting.

Requests use a valid/ready handshake. A request transfers on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle and no refresh is pending. A requester that sees `req_ready` low must hold `req_valid`, `req_addr` and `req_write` steady until the transfer. The configuration pins are plain levels. They must stay steady while an access or refresh is in progress. The refresh rate may change at any time.

Top module: `dram_seq_top`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle and no refresh is pending. Each transfer starts exactly one access, and the row strobe `ras_n` goes low in the cycle after the transfer edge.
- R2: `ras_n` stays low for (`cfg_rcd`+1) cycles, then for a further (`cfg_acc`+1) cycles.
- R3: `col_sel` is 1 in the last row-to-column cycle and in every access cycle, and 0 otherwise. `dram_addr` carries the upper half of `req_addr` when `col_sel`=0 and the lower half when `col_sel`=1.
- R4: Within the access cycles (counted from 1), `cas_n` is low in cycles 3 and 4 for `cfg_acc`=3, in cycles 2 and 3 for `cfg_acc`=2, and in cycle 2 only for `cfg_acc`=1. It is high in the other access cycles.
- R5: For `cfg_acc`=0, `cas_n` is low only while `clk` is low, in the single access cycle. It is high while `clk` is high.
- R6: After every access and every refresh, `ras_n` and `cas_n` are both high for (`cfg_rp`+1) cycles.
- R7: With the sequencer idle, refresh cycles start every 512, 256 or 128 clock cycles for `cfg_ref` = 00, 01 or 10 respectively.
- R8: A refresh holds `cas_n` low with `ras_n` high for one cycle. It then holds both low for (`cfg_acc`+1) cycles, then applies the precharge of R6.
- R9: A refresh that falls due during an access starts in the cycle right after that access's precharge, ahead of a waiting request, with `req_ready` low.
- R10: `cfg_ref` = 11 disables refresh, resets the interval count and discards a pending refresh.
- R11: `we_n` is low in the row-strobe-active cycles of an access whose `req_write` was 1, and high otherwise.
- R12: After reset `ras_n`, `cas_n` and `we_n` are 1, `col_sel` is 0 and, with refresh disabled, `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge starts a cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | AW (16) | Row in upper half, column in lower half |
| req_write | input | 1 | Request is a write |
| cfg_rcd | input | 2 | Row-to-column delay, code+1 cycles |
| cfg_acc | input | 2 | Access length, code+1 cycles |
| cfg_rp | input | 2 | Precharge length, code+1 cycles |
| cfg_ref | input | 2 | Refresh interval: 00=512, 01=256, 10=128, 11=off |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| col_sel | output | 1 | Address mux: 0 row, 1 column |
| dram_addr | output | AW/2 (8) | Multiplexed DRAM address |
| we_n | output | 1 | Write enable, active low |

## Verification
A wrong phase or count inside the sequencer shows up on the strobes within the same access. One cycle too few or too many moves a `ras_n` or `cas_n` edge, and the per-cycle comparison of the strobes and `col_sel` against the programmed codes catches it during that access. A wrong interval count or a stuck pending flag shows up later, at the next expected refresh start. That start comes at most one interval away, and the bench measures it exactly. The same fault can also show as a refresh that does not appear right after a busy precharge, or as one that appears after refresh was switched off.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RCD,
    ST_ACC,
    ST_PRE,
    ST_RCAS,
    ST_RRAS
  } seq_state_t;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int BASE_INT = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       ack,
  output logic       pending
);
  localparam int CW = $clog2(BASE_INT);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          off;

  assign off = (rate_sel == 2'b11);

  always_comb begin
    case (rate_sel)
      2'b00:   limit = CW'(BASE_INT - 1);
      2'b01:   limit = CW'((BASE_INT / 2) - 1);
      default: limit = CW'((BASE_INT / 4) - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else if (off) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else if (cnt >= limit) begin
      cnt     <= '0;
      pending <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      if (ack) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [1:0]    cfg_rcd,
  input  logic [1:0]    cfg_acc,
  input  logic [1:0]    cfg_rp,
  input  logic          ref_pending,
  output logic          ref_ack,
  output logic          ras_n,
  output logic          cas_main_n,
  output logic          cas_half,
  output logic          col_sel,
  output logic          we_n,
  output logic [AW-1:0] addr_q
);
  seq_state_t state;
  logic [1:0] cnt;
  logic       wr_q;
  logic       pre_last;
  logic       acc_cas;

  assign pre_last  = (state == ST_PRE) && (cnt == cfg_rp);
  assign ref_ack   = ref_pending && ((state == ST_IDLE) || pre_last);
  assign req_ready = (state == ST_IDLE) && !ref_pending;

  assign acc_cas = (cfg_acc != 2'd0) && (cnt != 2'd0) && (cnt >= cfg_acc - 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (ref_pending) begin
            state <= ST_RCAS;
          end else if (req_valid) begin
            state  <= ST_RCD;
            addr_q <= req_addr;
            wr_q   <= req_write;
          end
        end
        ST_RCD: begin
          if (cnt == cfg_rcd) begin
            state <= ST_ACC;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACC, ST_RRAS: begin
          if (cnt == cfg_acc) begin
            state <= ST_PRE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PRE: begin
          if (pre_last) begin
            cnt   <= '0;
            state <= ref_pending ? ST_RCAS : ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RCAS: begin
          state <= ST_RRAS;
          cnt   <= '0;
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign ras_n      = !((state == ST_RCD) || (state == ST_ACC) || (state == ST_RRAS));
  assign cas_main_n = !((state == ST_RCAS) || (state == ST_RRAS) ||
                        ((state == ST_ACC) && acc_cas));
  assign cas_half   = (state == ST_ACC) && (cfg_acc == 2'd0);
  assign col_sel    = ((state == ST_RCD) && (cnt == cfg_rcd)) || (state == ST_ACC);
  assign we_n       = !(wr_q && ((state == ST_RCD) || (state == ST_ACC)));
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int AW = 16
) (
  input  logic [AW-1:0]   addr_q,
  input  logic            col_sel,
  output logic [AW/2-1:0] dram_addr
);
  localparam int HW = AW / 2;

  assign dram_addr = col_sel ? addr_q[HW-1:0] : addr_q[AW-1:HW];
endmodule

// File: rtl/dram_seq_top.sv
module dram_seq_top #(
  parameter int AW       = 16,
  parameter int BASE_INT = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_write,
  input  logic [1:0]      cfg_rcd,
  input  logic [1:0]      cfg_acc,
  input  logic [1:0]      cfg_rp,
  input  logic [1:0]      cfg_ref,
  output logic            ras_n,
  output logic            cas_n,
  output logic            col_sel,
  output logic [AW/2-1:0] dram_addr,
  output logic            we_n
);
  logic          ref_pending;
  logic          ref_ack;
  logic          cas_main_n;
  logic          cas_half;
  logic [AW-1:0] addr_q;

  dram_refresh_timer #(.BASE_INT(BASE_INT)) timer_i (
    .clk(clk), .rst_n(rst_n), .rate_sel(cfg_ref), .ack(ref_ack), .pending(ref_pending)
  );

  dram_seq_fsm #(.AW(AW)) fsm_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .cfg_rcd(cfg_rcd), .cfg_acc(cfg_acc),
    .cfg_rp(cfg_rp), .ref_pending(ref_pending), .ref_ack(ref_ack), .ras_n(ras_n),
    .cas_main_n(cas_main_n), .cas_half(cas_half), .col_sel(col_sel), .we_n(we_n),
    .addr_q(addr_q)
  );

  dram_addr_mux #(.AW(AW)) mux_i (
    .addr_q(addr_q), .col_sel(col_sel), .dram_addr(dram_addr)
  );

  // single-cycle access: column strobe only in the low clock phase
  assign cas_n = cas_main_n & ~(cas_half & ~clk);
endmodule

// File: rtl/dram_seq_checker.sv
module dram_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       ras_n,
  input logic       col_sel,
  input logic       cas_main_n,
  input logic       cas_half,
  input logic [1:0] cfg_ref
);
  a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ras_n && cas_main_n));

  a_r1_transfer_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !ras_n);

  a_r3_col_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_sel) |-> !ras_n);

  a_r5_half_alone: assert property (@(posedge clk) disable iff (!rst_n)
    cas_half |-> (cas_main_n && !ras_n && col_sel));

  a_r6_precharge_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);

  a_r8_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_main_n) |-> $past(!cas_main_n));

  a_r10_no_ref_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ref == 2'b11 && $past(cfg_ref) == 2'b11 && $past(cfg_ref, 2) == 2'b11)
      |-> !($fell(cas_main_n) && ras_n));
endmodule

bind dram_seq_top dram_seq_checker chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ras_n(ras_n), .col_sel(col_sel), .cas_main_n(cas_main_n), .cas_half(cas_half),
  .cfg_ref(cfg_ref)
);

// File: tb/dram_seq_top_tb_top.sv
module dram_seq_top_tb_top;
  localparam int AW = 16;
  localparam int HW = AW / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic [1:0]    cfg_rcd = 2'd0, cfg_acc = 2'd0, cfg_rp = 2'd0, cfg_ref = 2'b11;
  logic          ras_n, cas_n, col_sel, we_n;
  logic [HW-1:0] dram_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int kill_at = -1;
  bit done = 0;

  dram_seq_top #(.AW(AW), .BASE_INT(512)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .cfg_rcd(cfg_rcd), .cfg_acc(cfg_acc),
    .cfg_rp(cfg_rp), .cfg_ref(cfg_ref), .ras_n(ras_n), .cas_n(cas_n),
    .col_sel(col_sel), .dram_addr(dram_addr), .we_n(we_n)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // expected {ras_n, cas_n, col_sel} in low clock phase of access cycle i
  function automatic logic [2:0] exp_strobes(input int rcd, input int acc, input int i);
    int nr = rcd + 1;
    int na = acc + 1;
    int j;
    if (i < nr) return {1'b0, 1'b1, (i == nr - 1)};
    if (i < nr + na) begin
      j = i - nr + 1;
      if (acc == 0) return 3'b001;
      if (acc == 3) return {1'b0, !(j >= 3), 1'b1};
      if (acc == 2) return {1'b0, !(j == 2 || j == 3), 1'b1};
      return {1'b0, !(j == 2), 1'b1};
    end
    return 3'b110;
  endfunction

  task automatic do_access(input int rcd, input int acc, input int rp,
                           input logic [AW-1:0] a, input logic wr);
    int total = rcd + acc + rp + 3;
    logic [2:0] e;
    @(negedge clk);
    cfg_rcd = 2'(rcd); cfg_acc = 2'(acc); cfg_rp = 2'(rp);
    req_addr = a; req_write = wr; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    for (int i = 0; i < total; i++) begin
      if (i > 0) @(posedge clk);
      #1;
      if (i == 0) req_valid = 1'b0;
      if (acc == 0 && i == rcd + 1) check("R5 high-phase cas_n", cas_n, 1);
      #2;
      if (i == kill_at) cfg_ref = 2'b11;
      e = exp_strobes(rcd, acc, i);
      check("R2 ras_n", ras_n, e[2]);
      check(acc == 0 ? "R5 cas_n" : "R4 cas_n", cas_n, e[1]);
      check("R3 col_sel", col_sel, e[0]);
      if (i >= rcd + acc + 2) check("R6 precharge cas_n", cas_n, 1);
      if (i < rcd + acc + 2) begin
        check("R3 dram_addr", dram_addr, e[0] ? a[HW-1:0] : a[AW-1:HW]);
        check("R11 we_n", we_n, !wr);
      end else begin
        check("R11 we_n idle", we_n, 1);
      end
      check("R1 ready busy", req_ready, 0);
    end
  endtask

  task automatic wait_ref_start(output int t);
    int lim = 0;
    do begin
      @(posedge clk); #3; lim++;
    end while (!(!cas_n && ras_n) && lim < 2000);
    t = cyc;
  endtask

  initial begin
    int t0, t1, t2;
    void'($urandom(32'd1234));
    #9 rst_n = 1'b1;
    @(posedge clk); #3;
    check("R12 ras_n", ras_n, 1);
    check("R12 cas_n", cas_n, 1);
    check("R12 we_n", we_n, 1);
    check("R12 col_sel", col_sel, 0);
    check("R12 req_ready", req_ready, 1);

    // directed corners: all code extremes
    do_access(0, 0, 0, 16'hA55A, 1'b1);
    do_access(3, 3, 3, 16'h1234, 1'b0);
    do_access(1, 1, 2, 16'hF00F, 1'b1);
    do_access(2, 2, 1, 16'h0FF0, 1'b0);
    @(negedge clk); #1;
    check("R1 ready idle", req_ready, 1);

    // random accesses, refresh off
    for (int n = 0; n < 40; n++) begin
      do_access(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                int'($urandom_range(0, 3)), 16'($urandom), 1'($urandom));
    end

    // disabled refresh stays silent (R10)
    t0 = 0;
    repeat (700) begin @(posedge clk); #3; if (!cas_n) t0++; end
    check("R10 no refresh while off", t0, 0);

    // intervals (R7)
    for (int s = 0; s < 3; s++) begin
      cfg_ref = 2'(s);
      wait_ref_start(t0);
      wait_ref_start(t1);
      wait_ref_start(t2);
      check("R7 interval", t2 - t1, 512 >> s);
    end

    // refresh shape (R8, R6)
    cfg_acc = 2'd2; cfg_rp = 2'd1;
    wait_ref_start(t0);
    check("R8 ready low during refresh", req_ready, 0);
    for (int j = 0; j < 3; j++) begin
      @(posedge clk); #3;
      check("R8 ras_n low", ras_n, 0);
      check("R8 cas_n low", cas_n, 0);
    end
    for (int j = 0; j < 2; j++) begin
      @(posedge clk); #3;
      check("R6 ras_n high", ras_n, 1);
      check("R6 cas_n high", cas_n, 1);
    end

    // arbitration (R9)
    cfg_ref = 2'b10; cfg_acc = 2'd3; cfg_rp = 2'd3;
    wait_ref_start(t0);
    repeat (118) @(posedge clk);
    do_access(3, 3, 3, 16'hBEEF, 1'b1);
    req_valid = 1'b1;
    @(posedge clk); #3;
    check("R9 refresh first ras_n", ras_n, 1);
    check("R9 refresh first cas_n", cas_n, 0);
    check("R9 ready low", req_ready, 0);
    do_access(3, 3, 3, 16'hCAFE, 1'b0);

    // disabling discards a pending refresh (R10)
    wait_ref_start(t0);
    repeat (118) @(posedge clk);
    kill_at = 10;
    do_access(3, 3, 3, 16'h4242, 1'b0);
    kill_at = -1;
    t1 = 0;
    repeat (40) begin @(posedge clk); #3; if (!cas_n) t1++; end
    check("R10 pending cleared", t1, 0);
    check("R1 ready after clear", req_ready, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule